// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block walks a platform from fully unpowered to fully running by switching supply rails on one at a time. Each step waits for a condition before the next one starts: a regulator's power-good pin, a comparator flag that reports a sensed voltage above its threshold, or a fixed settling delay. The block first brings up the always-on rails and releases the hub's resume reset, which reaches the soft-off level. It then follows the host's sleep-state lines, first to standby and then to full power with the power-OK handshake.

Every wait on an input is bounded by a one-second limit. If the limit runs out during the first stage, the sequencer returns to all-off. If it runs out while entering standby or full power, the sequencer returns to soft-off. In both cases it raises a one-cycle forced-shutdown request and sets a sticky error flag. Every monitored input passes through a two-flop synchroniser. All delays and limits are derived from the clock-frequency parameter `CLK_HZ`.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, every rail enable, `hub_rst_n`, `sys_pok`, `hub_pok`, `shutdown_req` and `tmo_err` are 0, and `state_code` is 0. The state codes are 0 = all-off, 1 = soft-off, 2 = standby and 3 = on.
- R2: The first stage runs in a fixed order. A high `pwr_req` in all-off sets `en_5v` on the next cycle. `en_3v3` rises only after `pg_5v` is seen. `en_1v8` rises only after `ana_3v3_ok` is seen.
- R3: `hub_rst_n` is released at a fixed time after `en_1v8` rises, provided both `pg_1v8` and `pg_1v05` are already high. It rises exactly CLK_HZ/100+1 cycles later, a delay of 10 ms plus one evaluation cycle. At the same time `state_code` becomes 1.
- R4: In soft-off with no error pending, a high `slp_deep_n` starts a wait for both `pg_mem25` and `pg_mem12`. `state_code` stays 1 until both have been seen, then becomes 2.
- R5: In standby, a high `slp_stby_n` starts a wait for `ana_sus_ok`. `en_s0_grp` then rises, and `en_io` follows exactly CLK_HZ/500 cycles (2 ms) later. Once `pg_io` is seen, `sus_pg` and `en_vr` rise together.
- R6: `sys_pok` rises exactly CLK_HZ/500 cycles after `en_vr`. Once `vr_ready` is seen, `hub_pok` rises CLK_HZ/500 cycles later and `state_code` becomes 3.
- R7: If a first-stage wait lasts CLK_HZ cycles, the sequencer returns to all-off with every output low except the following. `shutdown_req` is high for exactly one cycle and `tmo_err` is set.
- R8: If a wait during standby or full-power entry lasts CLK_HZ cycles, the sequencer returns to soft-off. `state_code` is 1, `hub_rst_n` stays high and the full-power outputs are low. `shutdown_req` pulses for one cycle and `tmo_err` is set.
- R9: `tmo_err` stays set until `pwr_req` is seen high. While it is set, `slp_deep_n` and the memory power-goods have no effect in soft-off: `state_code` stays 1. Once `pwr_req` clears the flag, the standby wait resumes.
- R10: In soft-off, if any of `pg_5v`, `ana_3v3_ok`, `pg_1v8` or `pg_1v05` goes low, the sequencer returns to all-off with all outputs low and no shutdown request.
- R11: A monitored input takes effect through a two-flop synchroniser. A power-good that is driven between clock edges changes the output it gates three clock edges later.
- R12: In the on state, a low `slp_stby_n` returns the sequencer to standby (code 2) with every full-power output low. In standby, a low `slp_deep_n` returns it to soft-off (code 1) with `hub_rst_n` still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power-up request; also clears the error flag |
| pg_5v | input | 1 | 5 V rail power-good |
| ana_3v3_ok | input | 1 | Comparator: 3.3 V group at or above 3000 mV |
| pg_1v8 | input | 1 | 1.8 V rail power-good |
| pg_1v05 | input | 1 | 1.05 V primary rail power-good |
| slp_deep_n | input | 1 | Host deep-sleep line, high when deasserted |
| pg_mem25 | input | 1 | 2.5 V memory rail power-good |
| pg_mem12 | input | 1 | 1.2 V memory rail power-good |
| slp_stby_n | input | 1 | Host standby line, high when deasserted |
| ana_sus_ok | input | 1 | Comparator: 1.05 V sustain rail at or above 1000 mV |
| pg_io | input | 1 | I/O rail power-good |
| vr_ready | input | 1 | Core regulator ready |
| en_5v | output | 1 | 5 V rail enable |
| en_3v3 | output | 1 | Always-on 3.3 V group enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| hub_rst_n | output | 1 | Hub resume reset, high when released |
| en_s0_grp | output | 1 | Full-power rail group enable |
| en_io | output | 1 | I/O rail enable |
| sus_pg | output | 1 | Sustain power-good to the host |
| en_vr | output | 1 | Core regulator enable |
| sys_pok | output | 1 | System power-OK |
| hub_pok | output | 1 | Hub power-OK |
| shutdown_req | output | 1 | One-cycle forced-shutdown request |
| tmo_err | output | 1 | Sticky timeout error |
| state_code | output | 2 | 0 all-off, 1 soft-off, 2 standby, 3 on |

## Verification
A monitored input driven between edges changes its gated output three edges later. Two of those edges are in the synchroniser and one is the state register. The bench therefore samples that output at the second falling edge, where it must still be unchanged, and at the third, where it must have moved. A fixed delay of D cycles moves the next output exactly D cycles after the output that started it. A wait-state exit adds one edge when its condition is already true, so the bench samples one cycle before the due edge and at it. A timeout lands CLK_HZ cycles after its wait state is entered, and the bench checks `shutdown_req` in that cycle and in the cycle before and after.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_W5V,
        ST_W3V3,
        ST_W1V8,
        ST_DLY_RSM,
        ST_SOFF,
        ST_WMEM,
        ST_STBY,
        ST_WSUS,
        ST_DLY_GRP,
        ST_WIO,
        ST_DLY_VR,
        ST_WRDY,
        ST_DLY_POK,
        ST_ON
    } seq_state_e;

    // monitored inputs, all synchronised before use
    typedef struct packed {
        logic deep_n;
        logic stby_n;
        logic vr_rdy;
        logic pg_io;
        logic ana_sus;
        logic pg_m12;
        logic pg_m25;
        logic pg_1v05;
        logic pg_1v8;
        logic ana_3v3;
        logic pg_5v;
    } mon_t;

    localparam int MON_W = $bits(mon_t);

    typedef struct packed {
        logic en_5v;
        logic en_3v3;
        logic en_1v8;
        logic hub_rst_n;
        logic en_grp;
        logic en_io;
        logic sus_pg;
        logic en_vr;
        logic sys_pok;
        logic hub_pok;
    } drive_t;

    function automatic int unsigned ms_cycles(int unsigned hz, int unsigned ms);
        int unsigned c;
        c = (hz / 1000) * ms;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic drive_t decode(seq_state_e s);
        drive_t d;
        d.en_5v     = (s != ST_OFF);
        d.en_3v3    = (s >= ST_W3V3);
        d.en_1v8    = (s >= ST_W1V8);
        d.hub_rst_n = (s >= ST_SOFF);
        d.en_grp    = (s >= ST_DLY_GRP);
        d.en_io     = (s >= ST_WIO);
        d.sus_pg    = (s >= ST_DLY_VR);
        d.en_vr     = (s >= ST_DLY_VR);
        d.sys_pok   = (s >= ST_WRDY);
        d.hub_pok   = (s == ST_ON);
        return d;
    endfunction

    function automatic logic [1:0] code_of(seq_state_e s);
        if (s == ST_ON)        return 2'd3;
        else if (s >= ST_STBY) return 2'd2;
        else if (s >= ST_SOFF) return 2'd1;
        else                   return 2'd0;
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                q[i]      <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int unsigned TMO_CYC = 1000,
    parameter int unsigned RSM_CYC = 10,
    parameter int unsigned GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tmo_hit,
    output logic rsm_hit,
    output logic gap_hit
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt != CW'(TMO_CYC))
            cnt <= cnt + 1'b1;
    end

    assign tmo_hit = (cnt == CW'(TMO_CYC - 1));
    assign rsm_hit = (cnt == CW'(RSM_CYC - 1));
    assign gap_hit = (cnt == CW'(GAP_CYC - 1));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_req,
    input  mon_t       mon,
    input  logic       tmo_hit,
    input  logic       rsm_hit,
    input  logic       gap_hit,
    output seq_state_e state,
    output logic       restart,
    output logic       shutdown_req,
    output logic       tmo_err
);
    seq_state_e nxt;
    logic       tmo_now;
    logic       soff_ok;

    assign soff_ok = mon.pg_5v && mon.ana_3v3 && mon.pg_1v8 && mon.pg_1v05;

    always_comb begin
        nxt     = state;
        tmo_now = 1'b0;
        unique case (state)
            ST_OFF:     if (pwr_req) nxt = ST_W5V;
            ST_W5V:     if (mon.pg_5v) nxt = ST_W3V3;
                        else if (tmo_hit) begin nxt = ST_OFF; tmo_now = 1'b1; end
            ST_W3V3:    if (mon.ana_3v3) nxt = ST_W1V8;
                        else if (tmo_hit) begin nxt = ST_OFF; tmo_now = 1'b1; end
            ST_W1V8:    if (mon.pg_1v8 && mon.pg_1v05) nxt = ST_DLY_RSM;
                        else if (tmo_hit) begin nxt = ST_OFF; tmo_now = 1'b1; end
            ST_DLY_RSM: if (rsm_hit) nxt = ST_SOFF;
            ST_SOFF:    if (!soff_ok) nxt = ST_OFF;
                        else if (mon.deep_n && !tmo_err) nxt = ST_WMEM;
            ST_WMEM:    if (mon.pg_m25 && mon.pg_m12) nxt = ST_STBY;
                        else if (tmo_hit) begin nxt = ST_SOFF; tmo_now = 1'b1; end
            ST_STBY:    if (!mon.deep_n) nxt = ST_SOFF;
                        else if (mon.stby_n) nxt = ST_WSUS;
            ST_WSUS:    if (mon.ana_sus) nxt = ST_DLY_GRP;
                        else if (tmo_hit) begin nxt = ST_SOFF; tmo_now = 1'b1; end
            ST_DLY_GRP: if (gap_hit) nxt = ST_WIO;
            ST_WIO:     if (mon.pg_io) nxt = ST_DLY_VR;
                        else if (tmo_hit) begin nxt = ST_SOFF; tmo_now = 1'b1; end
            ST_DLY_VR:  if (gap_hit) nxt = ST_WRDY;
            ST_WRDY:    if (mon.vr_rdy) nxt = ST_DLY_POK;
                        else if (tmo_hit) begin nxt = ST_SOFF; tmo_now = 1'b1; end
            ST_DLY_POK: if (gap_hit) nxt = ST_ON;
            ST_ON:      if (!mon.stby_n) nxt = ST_STBY;
            default:    nxt = ST_OFF;
        endcase
    end

    assign restart = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_OFF;
            shutdown_req <= 1'b0;
            tmo_err      <= 1'b0;
        end else begin
            state        <= nxt;
            shutdown_req <= tmo_now;
            if (tmo_now)
                tmo_err <= 1'b1;
            else if (pwr_req)
                tmo_err <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_req,
    input  logic       pg_5v,
    input  logic       ana_3v3_ok,
    input  logic       pg_1v8,
    input  logic       pg_1v05,
    input  logic       slp_deep_n,
    input  logic       pg_mem25,
    input  logic       pg_mem12,
    input  logic       slp_stby_n,
    input  logic       ana_sus_ok,
    input  logic       pg_io,
    input  logic       vr_ready,
    output logic       en_5v,
    output logic       en_3v3,
    output logic       en_1v8,
    output logic       hub_rst_n,
    output logic       en_s0_grp,
    output logic       en_io,
    output logic       sus_pg,
    output logic       en_vr,
    output logic       sys_pok,
    output logic       hub_pok,
    output logic       shutdown_req,
    output logic       tmo_err,
    output logic [1:0] state_code
);
    localparam int unsigned TMO_CYC = CLK_HZ;
    localparam int unsigned RSM_CYC = ms_cycles(CLK_HZ, 10);
    localparam int unsigned GAP_CYC = ms_cycles(CLK_HZ, 2);

    mon_t             mon_raw;
    logic [MON_W-1:0] mon_q;
    mon_t             mon;
    seq_state_e       state;
    logic             restart, tmo_hit, rsm_hit, gap_hit;
    drive_t           drv;

    always_comb begin
        mon_raw.deep_n  = slp_deep_n;
        mon_raw.stby_n  = slp_stby_n;
        mon_raw.vr_rdy  = vr_ready;
        mon_raw.pg_io   = pg_io;
        mon_raw.ana_sus = ana_sus_ok;
        mon_raw.pg_m12  = pg_mem12;
        mon_raw.pg_m25  = pg_mem25;
        mon_raw.pg_1v05 = pg_1v05;
        mon_raw.pg_1v8  = pg_1v8;
        mon_raw.ana_3v3 = ana_3v3_ok;
        mon_raw.pg_5v   = pg_5v;
    end

    pwr_seq_sync #(.W(MON_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mon_raw),
        .q   (mon_q)
    );

    assign mon = mon_t'(mon_q);

    pwr_seq_timer #(
        .TMO_CYC (TMO_CYC),
        .RSM_CYC (RSM_CYC),
        .GAP_CYC (GAP_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tmo_hit (tmo_hit),
        .rsm_hit (rsm_hit),
        .gap_hit (gap_hit)
    );

    pwr_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pwr_req      (pwr_req),
        .mon          (mon),
        .tmo_hit      (tmo_hit),
        .rsm_hit      (rsm_hit),
        .gap_hit      (gap_hit),
        .state        (state),
        .restart      (restart),
        .shutdown_req (shutdown_req),
        .tmo_err      (tmo_err)
    );

    assign drv        = decode(state);
    assign en_5v      = drv.en_5v;
    assign en_3v3     = drv.en_3v3;
    assign en_1v8     = drv.en_1v8;
    assign hub_rst_n  = drv.hub_rst_n;
    assign en_s0_grp  = drv.en_grp;
    assign en_io      = drv.en_io;
    assign sus_pg     = drv.sus_pg;
    assign en_vr      = drv.en_vr;
    assign sys_pok    = drv.sys_pok;
    assign hub_pok    = drv.hub_pok;
    assign state_code = code_of(state);
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_req,
    input logic       en_5v,
    input logic       en_3v3,
    input logic       en_1v8,
    input logic       hub_rst_n,
    input logic       en_s0_grp,
    input logic       en_io,
    input logic       sus_pg,
    input logic       sys_pok,
    input logic       hub_pok,
    input logic       shutdown_req,
    input logic       tmo_err,
    input logic [1:0] state_code
);
    // R2: rails come up in order
    p_order_3v3_r2: assert property (@(posedge clk) disable iff (rst)
        en_3v3 |-> en_5v);
    p_order_1v8_r2: assert property (@(posedge clk) disable iff (rst)
        en_1v8 |-> en_3v3);

    // R3: hub reset is released only with the first-stage rails enabled
    p_hubrst_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hub_rst_n) |-> (en_1v8 && state_code == 2'd1));

    // R5: I/O rail only after the full-power group
    p_io_after_grp_r5: assert property (@(posedge clk) disable iff (rst)
        en_io |-> en_s0_grp);

    // R6: hub power-OK only with the whole handshake in place
    p_hubpok_r6: assert property (@(posedge clk) disable iff (rst)
        hub_pok |-> (sys_pok && sus_pg && en_io && state_code == 2'd3));

    // R7: shutdown request lasts one cycle
    p_shut_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> !shutdown_req);

    // R8: a shutdown request always comes with the error flag
    p_shut_err_r8: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> tmo_err);

    // R9: the error flag only falls after a power-up request
    p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(tmo_err) |-> $past(pwr_req));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_req      (pwr_req),
    .en_5v        (en_5v),
    .en_3v3       (en_3v3),
    .en_1v8       (en_1v8),
    .hub_rst_n    (hub_rst_n),
    .en_s0_grp    (en_s0_grp),
    .en_io        (en_io),
    .sus_pg       (sus_pg),
    .sys_pok      (sys_pok),
    .hub_pok      (hub_pok),
    .shutdown_req (shutdown_req),
    .tmo_err      (tmo_err),
    .state_code   (state_code)
);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 10_000;
    localparam int WDOG       = 150_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 0, pg_5v = 0, ana_3v3_ok = 0, pg_1v8 = 0, pg_1v05 = 0;
    logic slp_deep_n = 0, pg_mem25 = 0, pg_mem12 = 0, slp_stby_n = 0;
    logic ana_sus_ok = 0, pg_io = 0, vr_ready = 0;
    logic en_5v, en_3v3, en_1v8, hub_rst_n, en_s0_grp, en_io, sus_pg, en_vr;
    logic sys_pok, hub_pok, shutdown_req, tmo_err;
    logic [1:0] state_code;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_top #(.CLK_HZ(HZ)) u0 (.*);

    // expected timing, from the requirements
    function automatic int t_out();      return HZ;            endfunction
    function automatic int d_rsm();      return HZ / 100;      endfunction
    function automatic int d_gap();      return HZ / 500;      endfunction
    function automatic int sync_lat();   return 3;             endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        return 4 + int'($urandom % 37);
    endfunction

    task automatic boot_to_soff();
        pwr_req = 1; cyc(1); pwr_req = 0;
        chk("R2 en_5v on request", en_5v, 1);
        chk("R9 tmo_err cleared by request", tmo_err, 0);
        chk("R2 en_3v3 waits", en_3v3, 0);
        cyc(rnd());
        chk("R2 en_3v3 before pg_5v", en_3v3, 0);
        pg_5v = 1;
        cyc(sync_lat() - 1);
        chk("R11 en_3v3 not yet", en_3v3, 0);
        cyc(1);
        chk("R11 en_3v3 after sync", en_3v3, 1);
        chk("R2 en_1v8 waits", en_1v8, 0);
        cyc(rnd());
        chk("R2 en_1v8 before analog", en_1v8, 0);
        ana_3v3_ok = 1; pg_1v8 = 1; pg_1v05 = 1;
        cyc(sync_lat());
        chk("R2 en_1v8 after analog", en_1v8, 1);
        cyc(d_rsm());
        chk("R3 hub_rst_n held", hub_rst_n, 0);
        cyc(1);
        chk("R3 hub_rst_n released", hub_rst_n, 1);
        chk("R3 state soft-off", state_code, 1);
    endtask

    task automatic soff_to_on();
        slp_deep_n = 1; pg_mem25 = 1;
        cyc(rnd());
        chk("R4 one memory good only", state_code, 1);
        pg_mem12 = 1;
        cyc(sync_lat() - 1);
        chk("R4 standby not yet", state_code, 1);
        cyc(1);
        chk("R4 standby", state_code, 2);
        slp_stby_n = 1;
        cyc(rnd());
        chk("R5 group waits analog", en_s0_grp, 0);
        ana_sus_ok = 1;
        cyc(sync_lat());
        chk("R5 group on", en_s0_grp, 1);
        cyc(d_gap() - 1);
        chk("R5 io held", en_io, 0);
        cyc(1);
        chk("R5 io on", en_io, 1);
        cyc(rnd());
        chk("R5 vr waits io good", en_vr, 0);
        pg_io = 1;
        cyc(sync_lat());
        chk("R5 vr on", en_vr, 1);
        chk("R5 sustain good", sus_pg, 1);
        cyc(d_gap() - 1);
        chk("R6 sys_pok held", sys_pok, 0);
        cyc(1);
        chk("R6 sys_pok on", sys_pok, 1);
        cyc(rnd());
        chk("R6 hub_pok waits ready", hub_pok, 0);
        vr_ready = 1;
        cyc(sync_lat() - 1 + d_gap());
        chk("R6 hub_pok held", hub_pok, 0);
        cyc(1);
        chk("R6 hub_pok on", hub_pok, 1);
        chk("R6 state on", state_code, 3);
    endtask

    task automatic on_down_to_off();
        slp_stby_n = 0; vr_ready = 0; pg_io = 0; ana_sus_ok = 0;
        cyc(sync_lat());
        chk("R12 standby code", state_code, 2);
        chk("R12 full-power outputs off",
            {hub_pok, sys_pok, en_vr, sus_pg, en_io, en_s0_grp}, 0);
        slp_deep_n = 0; pg_mem25 = 0; pg_mem12 = 0;
        cyc(sync_lat());
        chk("R12 soft-off code", state_code, 1);
        chk("R12 hub reset stays released", hub_rst_n, 1);
        pg_1v05 = 0;
        cyc(sync_lat() - 1);
        chk("R10 still soft-off", state_code, 1);
        cyc(1);
        chk("R10 all-off code", state_code, 0);
        chk("R10 rails off", {en_5v, en_3v3, en_1v8, hub_rst_n}, 0);
        chk("R10 no shutdown request", shutdown_req, 0);
        pg_5v = 0; ana_3v3_ok = 0; pg_1v8 = 0;
        cyc(4);
    endtask

    initial begin : wdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        cyc(3);
        rst = 0;
        cyc(1);
        chk("R1 state code", state_code, 0);
        chk("R1 outputs low",
            {en_5v, en_3v3, en_1v8, hub_rst_n, en_s0_grp, en_io, sus_pg,
             en_vr, sys_pok, hub_pok, shutdown_req, tmo_err}, 0);

        for (int it = 0; it < 3; it++) begin
            boot_to_soff();
            soff_to_on();
            on_down_to_off();
        end

        // R7: first-stage timeout
        pwr_req = 1; cyc(1); pwr_req = 0;
        chk("R7 en_5v on", en_5v, 1);
        cyc(t_out() - 1);
        chk("R7 still waiting", en_5v, 1);
        chk("R7 no early request", shutdown_req, 0);
        cyc(1);
        chk("R7 back to all-off", en_5v, 0);
        chk("R7 code", state_code, 0);
        chk("R7 shutdown pulse", shutdown_req, 1);
        chk("R7 error set", tmo_err, 1);
        cyc(1);
        chk("R7 pulse ends", shutdown_req, 0);
        chk("R9 error sticky", tmo_err, 1);

        // R8: standby-entry timeout, then R9 blocking and clearing
        boot_to_soff();
        slp_deep_n = 1;
        cyc(sync_lat() - 1 + t_out());
        chk("R8 no early request", shutdown_req, 0);
        cyc(1);
        chk("R8 shutdown pulse", shutdown_req, 1);
        chk("R8 error set", tmo_err, 1);
        chk("R8 soft-off code", state_code, 1);
        chk("R8 hub reset kept", hub_rst_n, 1);
        pg_mem25 = 1; pg_mem12 = 1;
        cyc(40);
        chk("R9 blocked in soft-off", state_code, 1);
        chk("R9 no repeat request", shutdown_req, 0);
        pwr_req = 1; cyc(1); pwr_req = 0;
        chk("R9 error cleared", tmo_err, 0);
        cyc(2);
        chk("R9 standby resumes", state_code, 2);

        // R8: full-power entry timeout
        slp_stby_n = 1;
        cyc(sync_lat() - 1 + t_out());
        chk("R8 still standby", state_code, 2);
        cyc(1);
        chk("R8 fallback soft-off", state_code, 1);
        chk("R8 shutdown pulse s0", shutdown_req, 1);
        chk("R8 group off", en_s0_grp, 0);
        chk("R8 error set s0", tmo_err, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule